// File: doc/BRIEF.md
# Eight-bit Harvard Register CPU Core

This block is a small single-issue processor that executes one single-byte instruction per clock from a separate instruction store. It reads and writes data through its own data memory port. The data address space also holds memory-mapped peripherals, and those are decoded outside the core. The machine state is four 8-bit general registers, an 8-bit program counter and a one-bit equality flag. Constants reach register r3 four bits at a time. Jumps, loads and stores all take their address from a register.

The instruction and data stores answer in the same cycle: `imem_data` follows `imem_addr` combinationally, and so does `dmem_rdata` with `dmem_addr`. A store is committed on the clock edge that ends the cycle in which `dmem_we` is high.

The controller has two states:
- **RUN** executes the fetched instruction.
- **VECTOR** is a single cycle that reads the handler address from a fixed data location.

It has three transitions:
- **ACCEPT** (RUN to VECTOR): an unmasked interrupt request replaces the instruction at the current boundary.
- **RESUME** (VECTOR to RUN): taken after the vector has been loaded into the program counter.
- **STAY** (RUN to RUN): every other cycle.

Top module: `cpu8_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter, the flag and all four registers to zero. While reset is held, `dmem_we` stays low.
- R2: Instructions use opcode [7:4], destination [3:2] and source [1:0]. Opcodes 0 to 5 write the destination register, modulo 256, with the following results:
  - 0: the source value
  - 1: destination plus source
  - 2: destination minus source
  - 3: bitwise AND
  - 4: bitwise OR
  - 5: the bitwise inverse of the source
- R3: Opcodes 6, 7 and 8 shift the destination register by the full 8-bit source value:
  - 6 shifts left, logically.
  - 7 shifts right, logically.
  - 8 shifts right, arithmetically.
  An amount of 8 or more gives zero for 6 and 7, and gives all copies of the sign bit for 8.
- R4: Opcode 9 sets the flag when the destination equals the source and clears it otherwise. No other instruction alters the flag.
- R5: Opcode 10 loads the program counter with the source register when the flag is set. Otherwise it steps to the next address.
- R6: Opcode 11 with bits [3:2] = 00 loads the program counter with the source register. The byte 0xB4 is the interrupt return. Every other opcode-11 byte only steps the program counter.
- R7: Opcode 12 replaces r3[7:4] with bits [3:0] of the instruction, and opcode 13 replaces r3[3:0]. In both cases the other nibble keeps its value.
- R8: Opcode 14 loads the destination register from the data address held in the source register. Opcode 15 writes the destination register to that address.
- R9: Every instruction other than opcodes 10 and 11 advances the program counter by exactly one.
- R10: An interrupt is accepted only at an instruction boundary, and the instruction at that boundary is not executed. The core then spends one cycle reading data address 250 with no store, and the next fetch comes from the byte read there.
- R11: After an interrupt is accepted, further requests are ignored until the return (0xB4) executes. The return resumes at the instruction that was displaced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| irq | input | 1 | Level interrupt request |
| imem_addr | output | 8 | Instruction fetch address (program counter) |
| imem_data | input | 8 | Instruction byte at `imem_addr`, same cycle |
| dmem_addr | output | 8 | Data memory address |
| dmem_wdata | output | 8 | Data memory write value |
| dmem_we | output | 1 | Data memory write strobe |
| dmem_rdata | input | 8 | Data memory read value at `dmem_addr`, same cycle |

## Verification
The interrupt acceptance and the interrupt return can land in the same cycle. In that case the request stays high while the return is being fetched. The bench keeps `irq` asserted through the whole handler and checks three things:
- The return still executes, because the mask is only released at that edge.
- The next fetch is the displaced address.
- Acceptance follows one cycle later, with a second vector read.

Acceptance is also made to coincide with an executable nibble load. The handler's store of r3 shows that the displaced instruction had not run when the handler began.

// File: rtl/cpu8_pkg.sv
package cpu8_pkg;

    localparam int unsigned WORD_W  = 8;
    localparam int unsigned REG_CNT = 4;
    localparam int unsigned SEL_W   = $clog2(REG_CNT);
    localparam int unsigned NIB_W   = WORD_W / 2;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [SEL_W-1:0]  rsel_t;

    typedef enum logic [3:0] {
        OP_COPY  = 4'd0,
        OP_ADD   = 4'd1,
        OP_SUB   = 4'd2,
        OP_AND   = 4'd3,
        OP_OR    = 4'd4,
        OP_INV   = 4'd5,
        OP_SHL   = 4'd6,
        OP_SHR   = 4'd7,
        OP_ASR   = 4'd8,
        OP_CMP   = 4'd9,
        OP_BREQ  = 4'd10,
        OP_JUMP  = 4'd11,
        OP_NHI   = 4'd12,
        OP_NLO   = 4'd13,
        OP_LOAD  = 4'd14,
        OP_STORE = 4'd15
    } op_e;

    typedef enum logic {
        ST_RUN    = 1'b0,
        ST_VECTOR = 1'b1
    } state_e;

    localparam rsel_t JUMP_SUB_GO = '0;
    localparam word_t IRET_CODE   = 8'hB4;

endpackage

// File: rtl/cpu8_alu.sv
module cpu8_alu
    import cpu8_pkg::*;
(
    input  op_e   op,
    input  word_t a,
    input  word_t b,
    output word_t y,
    output logic  eq
);

    always_comb begin
        case (op)
            OP_COPY: y = b;
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_INV:  y = ~b;
            OP_SHL:  y = a << b;
            OP_SHR:  y = a >> b;
            OP_ASR:  y = word_t'($signed(a) >>> b);
            default: y = a;
        endcase
        eq = (a == b);
    end

endmodule

// File: rtl/cpu8_regfile.sv
module cpu8_regfile
    import cpu8_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  rsel_t sel_a,
    input  rsel_t sel_b,
    input  logic  we,
    input  rsel_t wsel,
    input  word_t wdata,
    output word_t val_a,
    output word_t val_b
);

    word_t regs [REG_CNT];

    always_ff @(posedge clk) begin
        for (int i = 0; i < REG_CNT; i++) begin
            if (rst) begin
                regs[i] <= '0;
            end else if (we && wsel == rsel_t'(i)) begin
                regs[i] <= wdata;
            end
        end
    end

    assign val_a = regs[sel_a];
    assign val_b = regs[sel_b];

endmodule

// File: rtl/cpu8_ctrl.sv
module cpu8_ctrl
    import cpu8_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   irq,
    input  logic   iret_seen,
    output state_e st,
    output logic   accept
);

    state_e st_nx;
    logic   masked;
    logic   mask_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_RUN;
            masked <= 1'b0;
        end else begin
            st     <= st_nx;
            masked <= mask_nx;
        end
    end

    always_comb begin
        st_nx   = st;
        mask_nx = masked;
        accept  = 1'b0;
        unique case (st)
            ST_RUN: begin
                if (!rst && irq && !masked) begin
                    accept  = 1'b1;
                    st_nx   = ST_VECTOR;
                    mask_nx = 1'b1;
                end else if (iret_seen) begin
                    mask_nx = 1'b0;
                end
            end
            ST_VECTOR: begin
                st_nx = ST_RUN;
            end
        endcase
    end

endmodule

// File: rtl/cpu8_core.sv
module cpu8_core
    import cpu8_pkg::*;
#(
    parameter int unsigned VEC_ADDR = 250
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       irq,
    output logic [7:0] imem_addr,
    input  logic [7:0] imem_data,
    output logic [7:0] dmem_addr,
    output logic [7:0] dmem_wdata,
    output logic       dmem_we,
    input  logic [7:0] dmem_rdata
);

    localparam rsel_t IMM_REG = rsel_t'(REG_CNT - 1);

    word_t  pc, pc_nx, ret_pc;
    logic   flag, flag_nx;
    state_e st;
    logic   accept, exec, iret_hit;
    op_e    op;
    rsel_t  f_rd, f_rs, sel_a;
    word_t  val_a, val_b, alu_y, rf_wdata;
    logic   alu_eq, rf_we;

    assign op       = op_e'(imem_data[7:4]);
    assign f_rd     = imem_data[3:2];
    assign f_rs     = imem_data[1:0];
    assign sel_a    = (op == OP_NHI || op == OP_NLO) ? IMM_REG : f_rd;
    assign exec     = (st == ST_RUN) && !accept && !rst;
    assign iret_hit = (st == ST_RUN) && (imem_data == IRET_CODE);

    cpu8_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .irq       (irq),
        .iret_seen (iret_hit),
        .st        (st),
        .accept    (accept)
    );

    cpu8_regfile u_rf (
        .clk   (clk),
        .rst   (rst),
        .sel_a (sel_a),
        .sel_b (f_rs),
        .we    (rf_we),
        .wsel  (sel_a),
        .wdata (rf_wdata),
        .val_a (val_a),
        .val_b (val_b)
    );

    cpu8_alu u_alu (
        .op (op),
        .a  (val_a),
        .b  (val_b),
        .y  (alu_y),
        .eq (alu_eq)
    );

    always_comb begin
        pc_nx      = pc;
        flag_nx    = flag;
        rf_we      = 1'b0;
        rf_wdata   = alu_y;
        dmem_addr  = val_b;
        dmem_wdata = val_a;
        dmem_we    = 1'b0;
        if (st == ST_VECTOR) begin
            dmem_addr = word_t'(VEC_ADDR);
            pc_nx     = dmem_rdata;
        end else if (exec) begin
            pc_nx = pc + 1'b1;
            case (op)
                OP_COPY, OP_ADD, OP_SUB, OP_AND, OP_OR,
                OP_INV, OP_SHL, OP_SHR, OP_ASR: rf_we = 1'b1;
                OP_CMP:   flag_nx = alu_eq;
                OP_BREQ:  if (flag) pc_nx = val_b;
                OP_JUMP: begin
                    if (f_rd == JUMP_SUB_GO) begin
                        pc_nx = val_b;
                    end else if (imem_data == IRET_CODE) begin
                        pc_nx = ret_pc;
                    end
                end
                OP_NHI: begin
                    rf_we    = 1'b1;
                    rf_wdata = {imem_data[NIB_W-1:0], val_a[NIB_W-1:0]};
                end
                OP_NLO: begin
                    rf_we    = 1'b1;
                    rf_wdata = {val_a[WORD_W-1:NIB_W], imem_data[NIB_W-1:0]};
                end
                OP_LOAD: begin
                    rf_we    = 1'b1;
                    rf_wdata = dmem_rdata;
                end
                OP_STORE: dmem_we = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc     <= '0;
            flag   <= 1'b0;
            ret_pc <= '0;
        end else begin
            pc   <= pc_nx;
            flag <= flag_nx;
            if (accept) ret_pc <= pc;
        end
    end

    assign imem_addr = pc;

endmodule

// File: rtl/cpu8_core_chk.sv
module cpu8_core_chk
    import cpu8_pkg::*;
#(
    parameter int unsigned VEC_ADDR = 250
) (
    input logic       clk,
    input logic       rst,
    input logic [7:0] imem_addr,
    input logic [7:0] imem_data,
    input logic [7:0] dmem_addr,
    input logic       dmem_we,
    input logic [7:0] dmem_rdata,
    input state_e     st,
    input logic       accept,
    input logic       flag
);

    logic run_x, seq_op, cmp_x;
    assign run_x  = (st == ST_RUN) && !accept;
    assign seq_op = (imem_data[7:4] != 4'd10) && (imem_data[7:4] != 4'd11);
    assign cmp_x  = run_x && (imem_data[7:4] == 4'd9);

    // R9
    p_seq_step_r9: assert property (@(posedge clk) disable iff (rst)
        (run_x && seq_op) |=> (imem_addr == $past(imem_addr) + 8'd1));

    // R8
    p_store_gate_r8: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> (run_x && imem_data[7:4] == 4'hF));

    // R10
    p_vec_read_r10: assert property (@(posedge clk) disable iff (rst)
        (st == ST_VECTOR) |-> (dmem_addr == 8'(VEC_ADDR) && !dmem_we));

    // R10
    p_vec_load_r10: assert property (@(posedge clk) disable iff (rst)
        (st == ST_VECTOR) |=> (imem_addr == $past(dmem_rdata)));

    // R10
    p_hold_on_accept_r10: assert property (@(posedge clk) disable iff (rst)
        accept |=> (st == ST_VECTOR && $stable(imem_addr)));

    // R4
    p_flag_only_cmp_r4: assert property (@(posedge clk) disable iff (rst)
        !cmp_x |=> $stable(flag));

    // R1
    p_no_store_reset_r1: assert property (@(posedge clk)
        rst |-> !dmem_we);

endmodule

bind cpu8_core cpu8_core_chk #(.VEC_ADDR(VEC_ADDR)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .imem_data  (imem_data),
    .dmem_addr  (dmem_addr),
    .dmem_we    (dmem_we),
    .dmem_rdata (dmem_rdata),
    .st         (st),
    .accept     (accept),
    .flag       (flag)
);

// File: tb/cpu8_core_bench.sv
module cpu8_core_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 14;

    // {opcode, first operand, second operand, expected result}
    localparam logic [27:0] VEC_TAB [NVEC] = '{
        {4'h0, 8'h12, 8'h5A, 8'h5A},
        {4'h1, 8'hF0, 8'h20, 8'h10},
        {4'h1, 8'hFF, 8'h01, 8'h00},
        {4'h2, 8'h05, 8'h07, 8'hFE},
        {4'h3, 8'hCC, 8'hAA, 8'h88},
        {4'h4, 8'hCC, 8'hAA, 8'hEE},
        {4'h5, 8'h00, 8'h0F, 8'hF0},
        {4'h6, 8'h81, 8'h03, 8'h08},
        {4'h7, 8'h81, 8'h03, 8'h10},
        {4'h8, 8'h81, 8'h03, 8'hF0},
        {4'h8, 8'h70, 8'h02, 8'h1C},
        {4'h6, 8'hFF, 8'h09, 8'h00},
        {4'h7, 8'h80, 8'h08, 8'h00},
        {4'h8, 8'h80, 8'hC8, 8'hFF}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       irq = 1'b0;
    logic [7:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
    logic       dmem_we;
    logic [7:0] imem [256];
    logic [7:0] dmem [256];
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign imem_data  = imem[imem_addr];
    assign dmem_rdata = dmem[dmem_addr];

    always @(posedge clk) begin
        if (dmem_we) dmem[dmem_addr] <= dmem_wdata;
    end

    cpu8_core u_cpu8_core (
        .clk        (clk),
        .rst        (rst),
        .irq        (irq),
        .imem_addr  (imem_addr),
        .imem_data  (imem_data),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hold_reset();
        rst = 1'b1;
        irq = 1'b0;
        for (int i = 0; i < 256; i++) begin
            imem[i] = 8'h00;
            dmem[i] = 8'h00;
        end
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic release_reset();
        rst = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        // R1: reset state and zeroed registers and flag
        hold_reset();
        dmem[0] = 8'h55;
        imem[0] = 8'hF1;
        imem[1] = 8'hD8;
        imem[2] = 8'hA3;
        chk("R1 pc in reset", imem_addr, 8'h00);
        chk("R1 no store in reset", {7'd0, dmem_we}, 8'h00);
        release_reset();
        step(1);
        chk("R1 r0 zero after reset", dmem[0], 8'h00);
        step(2);
        chk("R1 flag zero, je not taken (R5)", imem_addr, 8'h03);

        // R2 R3: operation vectors
        for (int v = 0; v < NVEC; v++) begin
            logic [3:0] op;
            logic [7:0] a, b, e;
            {op, a, b, e} = VEC_TAB[v];
            hold_reset();
            imem[0] = {4'hC, a[7:4]};
            imem[1] = {4'hD, a[3:0]};
            imem[2] = 8'h03;
            imem[3] = {4'hC, b[7:4]};
            imem[4] = {4'hD, b[3:0]};
            imem[5] = 8'h07;
            imem[6] = {op, 4'b0001};
            imem[7] = 8'hC1;
            imem[8] = 8'hD0;
            imem[9] = 8'hF3;
            release_reset();
            step(12);
            chk((op >= 4'd6 && op <= 4'd8) ? "R3 shift result" : "R2 alu result",
                dmem[16], e);
        end

        // R7: nibble loads preserve the other half
        hold_reset();
        imem[0] = 8'hDA;
        imem[1] = 8'hC5;
        imem[2] = 8'hD3;
        imem[3] = 8'hFF;
        release_reset();
        step(4);
        chk("R7 nibble merge", dmem[8'h53], 8'h53);

        // R8: load then store
        hold_reset();
        dmem[8'h40] = 8'h9D;
        imem[0] = 8'hC4;
        imem[1] = 8'hD0;
        imem[2] = 8'hE7;
        imem[3] = 8'hC5;
        imem[4] = 8'hD0;
        imem[5] = 8'hF7;
        release_reset();
        step(6);
        chk("R8 load-store copy", dmem[8'h50], 8'h9D);

        // R4 R5 R6: compare and jumps
        hold_reset();
        imem[0]     = 8'h91;
        imem[1]     = 8'hC2;
        imem[2]     = 8'hD0;
        imem[3]     = 8'hA3;
        imem[8'h20] = 8'h9C;
        imem[8'h21] = 8'hA3;
        imem[8'h22] = 8'hB8;
        imem[8'h23] = 8'hB0;
        release_reset();
        step(4);
        chk("R4 equal sets flag, R5 je taken", imem_addr, 8'h20);
        step(2);
        chk("R4 unequal clears flag, R5 je falls through", imem_addr, 8'h22);
        step(1);
        chk("R6 other opcode-11 byte steps", imem_addr, 8'h23);
        step(1);
        chk("R6 jmp to register", imem_addr, 8'h00);

        // R10 R11: interrupt, masking, return colliding with request
        hold_reset();
        dmem[8'd250] = 8'h80;
        imem[0]     = 8'hD1;
        imem[1]     = 8'hD2;
        imem[2]     = 8'hD3;
        imem[8'h80] = 8'hFC;
        imem[8'h81] = 8'hB4;
        release_reset();
        step(2);
        irq = 1'b1;
        step(1);
        chk("R10 vector read address", dmem_addr, 8'd250);
        chk("R10 no store while fetching vector", {7'd0, dmem_we}, 8'h00);
        step(1);
        chk("R10 fetch from vector", imem_addr, 8'h80);
        step(1);
        chk("R11 request masked in handler", imem_addr, 8'h81);
        chk("R10 displaced instruction not run", dmem[0], 8'h02);
        step(1);
        chk("R11 return to displaced address", imem_addr, 8'h02);
        step(1);
        chk("R11 re-accept after return", dmem_addr, 8'd250);
        irq = 1'b0;
        step(4);
        chk("R11 resumes and executes displaced", imem_addr, 8'h03);
        step(1);
        chk("R9 step after resume", imem_addr, 8'h04);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule